// File: doc/BRIEF.md
# Single-Channel Texel Block Decoder

This block expands one compressed 4x4 tile of a single 8-bit channel into sixteen texel values. Each 64-bit tile holds two 8-bit reference levels and a 3-bit selector for every texel. The two references, taken in the order they are stored, pick one of two palette modes. In the first mode the palette is the two references plus six evenly spaced levels between them. In the second it is the two references, four levels between them, and the two fixed extremes, zero and full scale.

A tile enters on `blk_i` with `vld_i` and may arrive on any cycle, including back to back. The decoded texels appear on `tex_o` with `vld_o` exactly two cycles later. A two-channel tile of 16 bytes is decoded by two instances, one fed with each 8-byte half.

Top module: `alpha_block_decoder`

## Requirements
- R1: Reference level A is `blk_i[7:0]` and reference level B is `blk_i[15:8]`. Selector code 0 yields A and code 1 yields B.
- R2: Texel t = 4*row + col takes its 3-bit selector from `blk_i[16+3t+2 : 16+3t]`.
- R3: When A > B, selector code k in 2..7 yields round((((8-k)*A) + ((k-1)*B)) / 7), computed as (num+3)/7 in integer arithmetic.
- R4: When A <= B, selector code k in 2..5 yields (((6-k)*A) + ((k-1)*B) + 2)/5, code 6 yields 0 and code 7 yields 255.
- R5: Equal references select the mode of R4, so codes 0 to 5 all yield the shared value.
- R6: `vld_o` is high exactly two cycles after a cycle with `vld_i` high and low otherwise. A new tile is accepted every cycle.
- R7: While no new result is produced, `tex_o` holds the last decoded tile.
- R8: After reset `vld_o` is 0 and `tex_o` is all zeros.
- R9: Texel t appears on `tex_o[8t+7 : 8t]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| vld_i | input | 1 | A tile is presented this cycle |
| blk_i | input | 64 | Compressed tile: two references, then 48 selector bits |
| vld_o | output | 1 | Decoded tile valid |
| tex_o | output | 128 | Sixteen decoded 8-bit texels, texel 0 in the low byte |

## Verification
The bench targets mode selection at its boundary: equal references, and references one apart in each order. A design that compares with the wrong strictness would hand equal-reference tiles six interpolated levels instead of the fixed extremes. Tiles placed selectors 6 and 7 in every texel position and used full-scale references in both orders. These expose a swapped selector bit order, an off-by-one texel offset and a rounding that truncates instead of rounding to nearest. Back-to-back tiles and idle gaps are mixed so that a pipeline which drops or duplicates a tile, drifts in latency, or lets the output change when no tile arrives is caught.

// File: rtl/alpha_block_decoder.sv
module alpha_block_decoder #(
  parameter int TEXELS = 16,
  parameter int VAL_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      vld_i,
  input  logic [2*VAL_W+3*TEXELS-1:0] blk_i,
  output logic                      vld_o,
  output logic [TEXELS*VAL_W-1:0]   tex_o
);
  localparam int SEL_W  = 3;
  localparam int LEVELS = 1 << SEL_W;
  localparam int SEL_LO = 2 * VAL_W;
  localparam int MAXV   = (1 << VAL_W) - 1;

  function automatic logic [VAL_W-1:0] blend(input logic [VAL_W-1:0] a,
                                             input logic [VAL_W-1:0] b,
                                             input int wb, input int den);
    int s;
    s = (den - wb) * int'(a) + wb * int'(b);
    return VAL_W'((s + den / 2) / den);
  endfunction

  logic [VAL_W-1:0] ref_a, ref_b;
  logic [VAL_W-1:0] pal_d [LEVELS];
  logic [VAL_W-1:0] pal_q [LEVELS];
  logic [SEL_W*TEXELS-1:0] sel_q;
  logic s1_vld;

  assign ref_a = blk_i[VAL_W-1:0];
  assign ref_b = blk_i[2*VAL_W-1:VAL_W];

  always_comb begin
    pal_d[0] = ref_a;
    pal_d[1] = ref_b;
    for (int k = 2; k < LEVELS; k++) begin
      if (ref_a > ref_b)
        pal_d[k] = blend(ref_a, ref_b, k - 1, LEVELS - 1);
      else if (k < LEVELS - 2)
        pal_d[k] = blend(ref_a, ref_b, k - 1, LEVELS - 3);
      else if (k == LEVELS - 2)
        pal_d[k] = '0;
      else
        pal_d[k] = VAL_W'(MAXV);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_vld <= 1'b0;
      sel_q  <= '0;
      for (int k = 0; k < LEVELS; k++) pal_q[k] <= '0;
    end else begin
      s1_vld <= vld_i;
      if (vld_i) begin
        sel_q <= blk_i[SEL_LO +: SEL_W*TEXELS];
        for (int k = 0; k < LEVELS; k++) pal_q[k] <= pal_d[k];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_o <= 1'b0;
    else        vld_o <= s1_vld;
  end

  for (genvar t = 0; t < TEXELS; t++) begin : g_texel
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      tex_o[t*VAL_W +: VAL_W] <= '0;
      else if (s1_vld) tex_o[t*VAL_W +: VAL_W] <= pal_q[sel_q[t*SEL_W +: SEL_W]];
    end
  end

  a_r6_latency_hit: assert property (@(posedge clk) disable iff (!rst_n)
    vld_i |-> ##2 vld_o);
  a_r6_latency_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !vld_i |-> ##2 !vld_o);
  a_r1_code0_ref_a: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(blk_i[SEL_LO +: SEL_W], 2) == 3'd0)
      |-> tex_o[VAL_W-1:0] == $past(blk_i[VAL_W-1:0], 2));
  a_r1_code1_ref_b: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(blk_i[SEL_LO +: SEL_W], 2) == 3'd1)
      |-> tex_o[VAL_W-1:0] == $past(blk_i[2*VAL_W-1:VAL_W], 2));
  a_r4_top_full: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(blk_i[SEL_LO +: SEL_W], 2) == 3'd7
           && $past(blk_i[VAL_W-1:0] <= blk_i[2*VAL_W-1:VAL_W], 2))
      |-> tex_o[VAL_W-1:0] == VAL_W'(MAXV));
  a_r4_six_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && $past(blk_i[SEL_LO +: SEL_W], 2) == 3'd6
           && $past(blk_i[VAL_W-1:0] <= blk_i[2*VAL_W-1:VAL_W], 2))
      |-> tex_o[VAL_W-1:0] == '0);
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !s1_vld |=> $stable(tex_o));
endmodule

// File: tb/alpha_block_decoder_bench.sv
`timescale 1ns/1ps
module alpha_block_decoder_bench;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         vld_i = 1'b0;
  logic [63:0]  blk_i = '0;
  logic         vld_o;
  logic [127:0] tex_o;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0, seen = 0;
  logic [127:0] exp_q[$];
  int           cyc_q[$];
  string        tag_q[$];
  logic [127:0] last_exp = '0;

  always #2.5 clk = ~clk;

  alpha_block_decoder u_alpha_block_decoder (
    .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .blk_i(blk_i),
    .vld_o(vld_o), .tex_o(tex_o));

  function automatic logic [7:0] level(input logic [7:0] a, input logic [7:0] b, input int k);
    int na = a, nb = b;
    if (k == 0) return a;
    if (k == 1) return b;
    if (na > nb) return 8'(((8 - k) * na + (k - 1) * nb + 3) / 7);
    if (k == 6) return 8'd0;
    if (k == 7) return 8'd255;
    return 8'(((6 - k) * na + (k - 1) * nb + 2) / 5);
  endfunction

  function automatic logic [127:0] model(input logic [63:0] b);
    logic [127:0] r;
    for (int t = 0; t < 16; t++)
      r[8*t +: 8] = level(b[7:0], b[15:8], int'(b[16 + 3*t +: 3]));
    return r;
  endfunction

  function automatic logic [63:0] pack(input logic [7:0] a, input logic [7:0] b, input int rot);
    logic [63:0] r;
    r = {48'd0, b, a};
    for (int t = 0; t < 16; t++) r[16 + 3*t +: 3] = 3'((t + rot) % 8);
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] b, input string tag);
    @(negedge clk);
    vld_i = 1'b1;
    blk_i = b;
    exp_q.push_back(model(b));
    cyc_q.push_back(cyc + 2);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      vld_i = 1'b0;
      blk_i = {$urandom, $urandom};
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (rst_n) begin
      if (vld_o) begin
        if (exp_q.size() == 0) begin
          check(0, "R6 unexpected vld_o", 128'(vld_o), 128'd0);
        end else begin
          logic [127:0] e;
          int c;
          string tg;
          e = exp_q.pop_front();
          c = cyc_q.pop_front();
          tg = tag_q.pop_front();
          check(c == cyc, "R6 latency", 128'(cyc), 128'(c));
          check(tex_o == e, tg, tex_o, e);
          last_exp = e;
          seen = 1;
        end
      end else if (seen) begin
        check(tex_o == last_exp, "R7 hold while idle", tex_o, last_exp);
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      check(0, "watchdog", 128'd0, 128'd1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(vld_o == 1'b0, "R8 reset vld_o", 128'(vld_o), 128'd0);
    check(tex_o == '0, "R8 reset tex_o", tex_o, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    check(tex_o == '0 && !vld_o, "R8 after release", tex_o, 128'd0);

    send(pack(8'd200, 8'd10, 0), "R3 R1 R9 wide mode");
    idle(3);
    send(pack(8'd10, 8'd200, 0), "R4 R1 narrow mode");
    idle(1);
    send(pack(8'd77, 8'd77, 3), "R5 equal refs");
    send(pack(8'd78, 8'd77, 5), "R3 refs one apart");
    send(pack(8'd77, 8'd78, 6), "R4 refs one apart");
    send(pack(8'd255, 8'd0, 1), "R3 full-scale wide");
    send(pack(8'd0, 8'd255, 2), "R4 full-scale narrow");
    send(pack(8'd1, 8'd0, 7), "R3 rounding small");
    idle(4);
    begin
      logic [63:0] b;
      b = '0;
      b[7:0] = 8'd9;
      b[15:8] = 8'd3;
      b[16 + 3*15 +: 3] = 3'd7;
      b[16 + 3*5 +: 3] = 3'd1;
      send(b, "R2 R9 texel offsets");
      b[16 + 3*15 +: 3] = 3'd4;
      send(b, "R2 selector bit order");
    end
    for (int i = 0; i < 200; i++) begin
      send({$urandom, $urandom}, "R3 R4 random tile");
      if (i % 7 == 3) idle(i % 3 + 1);
    end
    idle(6);
    check(exp_q.size() == 0, "R6 all tiles returned", 128'(exp_q.size()), 128'd0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule